// File: doc/BRIEF.md
# Multi-Mode Line Loss-of-Signal Monitor

This block watches a line receiver's per-interval pulse indication and decides whether the line has lost its signal. The receiver front end supplies a one-cycle strobe for each bit interval, along with a flag that says whether a pulse was detected in that interval. Amplitude thresholds and the analog comparison are handled upstream. The monitor applies one of three rule sets, each with its own declare and clear criteria. One rule serves 1.544 Mb/s (T1) lines. The other two serve 2.048 Mb/s (E1) lines, and a standard-select input chooses between them.

While the line is good, the monitor counts consecutive empty intervals and declares loss when the count reaches the rule's threshold. While loss is declared, it evaluates the line in fixed, back-to-back evaluation windows. The first window begins with the first interval after loss is declared. The loss condition is released only at the end of a window whose contents meet the rule's clear criterion. The monitor drives a real-time status, a sticky latched status that software clears, and an interrupt request gated by an enable input.

Top module: `los_monitor`

## Requirements
- R1: Out of reset the real-time status `los_rt` and the latched status `los_latched` are both 1.
- R2: With `mode_e1`=0 (T1 rule), `los_rt` rises after 192 consecutive strobed intervals with `pulse`=0, and not after 191.
- R3: Under the T1 rule, loss clears at the end of a 192-interval window that holds at least 24 pulses and no run of 100 or more consecutive empty intervals. A run of 99 is allowed. The run is counted from the window's first interval.
- R4: With `mode_e1`=1 and `std_sel`=0, loss is declared after 255 consecutive empty intervals, and not after 254.
- R5: With `mode_e1`=1 and `std_sel`=0, loss clears at the end of a 255-interval window holding at least 32 pulses. Zero runs are not considered under this rule.
- R6: With `mode_e1`=1 and `std_sel`=1, loss is declared after 2048 consecutive empty intervals, and not after 2047.
- R7: With `mode_e1`=1 and `std_sel`=1, loss clears at the end of a 255-interval window holding at least one pulse. A window with no pulse keeps loss asserted.
- R8: `los_latched` becomes 1 whenever `los_rt` is 1 and holds until `latch_clr` is pulsed. A `latch_clr` while `los_rt` is still 1 leaves it at 1.
- R9: `irq` equals `los_latched` when `irq_en`=1 and is 0 when `irq_en`=0.
- R10: A change of `mode_e1` or `std_sel` restarts the empty-interval count and the evaluation window.
- R11: `pulse` is ignored in any cycle where `bit_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One-cycle strobe per line bit interval |
| pulse | input | 1 | Pulse detected in this interval, valid with `bit_stb` |
| mode_e1 | input | 1 | 0 selects the T1 rule, 1 selects an E1 rule |
| std_sel | input | 1 | E1 only: 0 selects the 255/32 rule, 1 selects the 2048/1 rule |
| irq_en | input | 1 | Interrupt enable |
| latch_clr | input | 1 | One-cycle clear of the latched status |
| los_rt | output | 1 | Real-time loss-of-signal status |
| los_latched | output | 1 | Sticky loss-of-signal status |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `bit_stb` is a single-cycle strobe with at least one idle cycle between strobes. They also assume that `mode_e1` and `std_sel` change only while no strobe is present, so a reconfiguration never coincides with a counted interval. The bench drives every strobe as one high cycle followed by one low cycle. It changes the configuration only during idle cycles and waits two cycles before the next interval. All stimulus changes on the falling clock edge.

// File: rtl/los_pkg.sv
package los_pkg;

   // Rule selected from the mode and standard-select inputs.
   typedef enum logic [1:0] {
      RULE_T1        = 2'd0,
      RULE_E1_DENSE  = 2'd1,
      RULE_E1_SPARSE = 2'd2
   } los_rule_e;

   function automatic los_rule_e pick_rule(input logic e1, input logic sel);
      if (!e1)     return RULE_T1;
      else if (!sel) return RULE_E1_DENSE;
      else         return RULE_E1_SPARSE;
   endfunction

endpackage

// File: rtl/los_rule_sel.sv
module los_rule_sel
   import los_pkg::*;
#(
   parameter int CNT_W      = 12,
   parameter int T1_DECL    = 192,
   parameter int T1_WIN     = 192,
   parameter int T1_NEED    = 24,
   parameter int T1_ZLIM    = 100,
   parameter int E1D_DECL   = 255,
   parameter int E1D_WIN    = 255,
   parameter int E1D_NEED   = 32,
   parameter int E1S_DECL   = 2048,
   parameter int E1S_WIN    = 255,
   parameter int E1S_NEED   = 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_e1,
   input  logic             std_sel,
   output logic             cfg_chg,
   output logic [CNT_W-1:0] decl_len,
   output logic [CNT_W-1:0] win_len,
   output logic [CNT_W-1:0] need,
   output logic [CNT_W-1:0] run_lim,
   output logic             run_chk
);

   logic [1:0] cfg_q;
   los_rule_e  rule;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= 2'b00;
      else        cfg_q <= {mode_e1, std_sel};
   end

   // Restart request: in E1 mode any bit change counts, in T1 only the mode bit.
   assign cfg_chg = (cfg_q[1] != mode_e1) || (mode_e1 && (cfg_q[0] != std_sel));
   assign rule    = pick_rule(mode_e1, std_sel);

   always_comb begin
      decl_len = CNT_W'(T1_DECL);
      win_len  = CNT_W'(T1_WIN);
      need     = CNT_W'(T1_NEED);
      run_lim  = CNT_W'(T1_ZLIM);
      run_chk  = 1'b1;
      case (rule)
         RULE_E1_DENSE: begin
            decl_len = CNT_W'(E1D_DECL);
            win_len  = CNT_W'(E1D_WIN);
            need     = CNT_W'(E1D_NEED);
            run_chk  = 1'b0;
         end
         RULE_E1_SPARSE: begin
            decl_len = CNT_W'(E1S_DECL);
            win_len  = CNT_W'(E1S_WIN);
            need     = CNT_W'(E1S_NEED);
            run_chk  = 1'b0;
         end
         default: ;
      endcase
   end

   AST_LIMITS_SANE: assert property (@(posedge clk) disable iff (!rst_n)
      (win_len != '0) && (decl_len != '0) && (need <= win_len)); // R10

endmodule

// File: rtl/los_zero_run.sv
module los_zero_run #(
   parameter int CNT_W = 12,
   parameter int SAT   = 2048
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_stb,
   input  logic             pulse,
   input  logic             hold,
   input  logic [CNT_W-1:0] decl_len,
   output logic             declare
);

   localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);

   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] run_inc;

   assign run_inc = (run_q == SAT_V) ? SAT_V : run_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              run_q <= '0;
      else if (hold)           run_q <= '0;
      else if (bit_stb) begin
         if (pulse)            run_q <= '0;
         else                  run_q <= run_inc;
      end
   end

   assign declare = bit_stb && !pulse && !hold && (run_inc >= decl_len);

   AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= SAT_V); // R6

   AST_RUN_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_stb && !hold) |=> $stable(run_q)); // R11

endmodule

// File: rtl/los_clear_window.sv
module los_clear_window #(
   parameter int CNT_W        = 12,
   parameter bit RUN_CHECK_EN = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_stb,
   input  logic             pulse,
   input  logic             active,
   input  logic [CNT_W-1:0] win_len,
   input  logic [CNT_W-1:0] need,
   input  logic [CNT_W-1:0] run_lim,
   input  logic             run_chk,
   output logic             clear_hit,
   output logic             win_last
);

   logic [CNT_W-1:0] pos_q;
   logic [CNT_W-1:0] pcnt_q, pcnt_n;
   logic             bad_q, bad_n;

   assign win_last = (pos_q == win_len - 1'b1);
   assign pcnt_n   = (pulse && (pcnt_q < need)) ? pcnt_q + 1'b1 : pcnt_q;

   generate
      if (RUN_CHECK_EN) begin : g_run
         logic [CNT_W-1:0] zr_q, zr_n;
         assign zr_n  = pulse ? '0 : ((zr_q >= run_lim) ? run_lim : zr_q + 1'b1);
         assign bad_n = bad_q || (run_chk && (zr_n >= run_lim));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   zr_q <= '0;
            else if (!active)             zr_q <= '0;
            else if (bit_stb) zr_q <= win_last ? '0 : zr_n;
         end
      end else begin : g_norun
         assign bad_n = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         pcnt_q <= '0;
         bad_q  <= 1'b0;
      end else if (!active) begin
         pos_q  <= '0;
         pcnt_q <= '0;
         bad_q  <= 1'b0;
      end else if (bit_stb) begin
         if (win_last) begin
            pos_q  <= '0;
            pcnt_q <= '0;
            bad_q  <= 1'b0;
         end else begin
            pos_q  <= pos_q + 1'b1;
            pcnt_q <= pcnt_n;
            bad_q  <= bad_n;
         end
      end
   end

   assign clear_hit = active && bit_stb && win_last && (pcnt_n >= need) && !bad_n;

   AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q < win_len); // R3

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt_q <= need); // R5

endmodule

// File: rtl/los_status.sv
module los_status (
   input  logic clk,
   input  logic rst_n,
   input  logic declare,
   input  logic clear_hit,
   input  logic latch_clr,
   input  logic irq_en,
   output logic los_rt,
   output logic los_latched,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         los_rt <= 1'b1;
      else if (declare)   los_rt <= 1'b1;
      else if (clear_hit) los_rt <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) los_latched <= 1'b1;
      else        los_latched <= los_rt | (los_latched & ~latch_clr);
   end

   assign irq = los_latched & irq_en;

   AST_LATCH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      los_rt |=> los_latched); // R8

   AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (los_latched && !latch_clr) |=> los_latched); // R8

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq); // R9

endmodule

// File: rtl/los_monitor.sv
module los_monitor #(
   parameter int T1_DECL      = 192,
   parameter int T1_WIN       = 192,
   parameter int T1_NEED      = 24,
   parameter int T1_ZLIM      = 100,
   parameter int E1D_DECL     = 255,
   parameter int E1D_WIN      = 255,
   parameter int E1D_NEED     = 32,
   parameter int E1S_DECL     = 2048,
   parameter int E1S_WIN      = 255,
   parameter int E1S_NEED     = 1,
   parameter bit RUN_CHECK_EN = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic bit_stb,
   input  logic pulse,
   input  logic mode_e1,
   input  logic std_sel,
   input  logic irq_en,
   input  logic latch_clr,
   output logic los_rt,
   output logic los_latched,
   output logic irq
);

   localparam int DECL_MAX = (T1_DECL > E1D_DECL) ?
                             ((T1_DECL > E1S_DECL) ? T1_DECL : E1S_DECL) :
                             ((E1D_DECL > E1S_DECL) ? E1D_DECL : E1S_DECL);
   localparam int CNT_W    = $clog2(DECL_MAX + 1) + 1;

   generate
      if (T1_NEED > T1_WIN || E1D_NEED > E1D_WIN || E1S_NEED > E1S_WIN) begin : g_bad_need
         $error("los_monitor: pulse quota exceeds window length");
      end
      if (T1_ZLIM > T1_WIN) begin : g_bad_zlim
         $error("los_monitor: zero-run limit exceeds window length");
      end
   endgenerate

   logic             cfg_chg;
   logic [CNT_W-1:0] decl_len, win_len, need, run_lim;
   logic             run_chk;
   logic             declare, clear_hit, win_last;

   los_rule_sel #(
      .CNT_W(CNT_W),
      .T1_DECL(T1_DECL), .T1_WIN(T1_WIN), .T1_NEED(T1_NEED), .T1_ZLIM(T1_ZLIM),
      .E1D_DECL(E1D_DECL), .E1D_WIN(E1D_WIN), .E1D_NEED(E1D_NEED),
      .E1S_DECL(E1S_DECL), .E1S_WIN(E1S_WIN), .E1S_NEED(E1S_NEED)
   ) u_rule (
      .clk(clk), .rst_n(rst_n), .mode_e1(mode_e1), .std_sel(std_sel),
      .cfg_chg(cfg_chg), .decl_len(decl_len), .win_len(win_len),
      .need(need), .run_lim(run_lim), .run_chk(run_chk)
   );

   los_zero_run #(.CNT_W(CNT_W), .SAT(DECL_MAX)) u_run (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .pulse(pulse),
      .hold(los_rt || cfg_chg), .decl_len(decl_len), .declare(declare)
   );

   los_clear_window #(.CNT_W(CNT_W), .RUN_CHECK_EN(RUN_CHECK_EN)) u_win (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .pulse(pulse),
      .active(los_rt && !cfg_chg), .win_len(win_len), .need(need),
      .run_lim(run_lim), .run_chk(run_chk),
      .clear_hit(clear_hit), .win_last(win_last)
   );

   los_status u_stat (
      .clk(clk), .rst_n(rst_n), .declare(declare), .clear_hit(clear_hit),
      .latch_clr(latch_clr), .irq_en(irq_en),
      .los_rt(los_rt), .los_latched(los_latched), .irq(irq)
   );

   AST_RISE_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(los_rt) |-> $past(bit_stb && !pulse)); // R2

   AST_FALL_AT_WIN_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(los_rt) |-> $past(bit_stb && win_last)); // R3

   AST_NO_DUAL_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      !(declare && clear_hit)); // R10

endmodule

// File: tb/los_monitor_tb.sv
`timescale 1ns/1ps
module los_monitor_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_stb = 1'b0, pulse = 1'b0, mode_e1 = 1'b0, std_sel = 1'b0;
   logic irq_en = 1'b0, latch_clr = 1'b0;
   logic los_rt, los_latched, irq;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   los_monitor u_dut (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .pulse(pulse),
      .mode_e1(mode_e1), .std_sel(std_sel), .irq_en(irq_en),
      .latch_clr(latch_clr), .los_rt(los_rt), .los_latched(los_latched), .irq(irq)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic send_bit(input logic p);
      @(negedge clk);
      bit_stb = 1'b1;
      pulse   = p;
      @(negedge clk);
      bit_stb = 1'b0;
      pulse   = 1'b0;
   endtask

   task automatic send_zeros(input int n);
      for (int i = 0; i < n; i++) send_bit(1'b0);
   endtask

   // Every k-th interval of n carries a pulse (k=0 means none).
   task automatic send_spaced(input int n, input int k, input int lim);
      for (int i = 0; i < n; i++) send_bit(k != 0 && (i % k == 0) && (i < lim));
   endtask

   task automatic t_reset;
      idle(2);
      check("R1 los_rt after reset", los_rt, 1'b1);
      check("R1 latched after reset", los_latched, 1'b1);
      check("R9 irq masked", irq, 1'b0);
   endtask

   task automatic t_t1_first_clear;
      send_spaced(191, 4, 192);
      check("R3 no clear before window end", los_rt, 1'b1);
      send_bit(1'b0);
      check("R3 clear at window end", los_rt, 1'b0);
   endtask

   task automatic t_latch_irq;
      // los_rt now 0; latch still set from reset
      idle(1);
      check("R8 latch held", los_latched, 1'b1);
      irq_en = 1'b1;
      idle(1);
      check("R9 irq follows latch", irq, 1'b1);
      latch_clr = 1'b1;
      idle(1);
      latch_clr = 1'b0;
      idle(1);
      check("R8 latch cleared", los_latched, 1'b0);
      check("R9 irq drops", irq, 1'b0);
   endtask

   task automatic t_t1_declare;
      send_zeros(191);
      check("R2 no declare at 191", los_rt, 1'b0);
      send_bit(1'b0);
      check("R2 declare at 192", los_rt, 1'b1);
      idle(1);
      check("R8 latch set", los_latched, 1'b1);
      check("R9 irq raised", irq, 1'b1);
      latch_clr = 1'b1;
      idle(1);
      latch_clr = 1'b0;
      idle(1);
      check("R8 clear ignored while active", los_latched, 1'b1);
      irq_en = 1'b0;
   endtask

   task automatic t_t1_runs;
      // 24 pulses, run of 100 zeros, one pulse, 67 zeros: no clear
      for (int i = 0; i < 192; i++) send_bit(i < 24 || i == 124);
      check("R3 run of 100 blocks clear", los_rt, 1'b1);
      // 24 pulses, run of 99 zeros, one pulse, 68 zeros: clear
      for (int i = 0; i < 192; i++) send_bit(i < 24 || i == 123);
      check("R3 run of 99 allows clear", los_rt, 1'b0);
      send_zeros(192);
      check("R2 redeclare", los_rt, 1'b1);
      send_spaced(192, 8, 184);
      check("R3 23 pulses no clear", los_rt, 1'b1);
      send_spaced(192, 8, 192);
      check("R3 24 pulses clear", los_rt, 1'b0);
   endtask

   task automatic t_mode_change;
      send_zeros(150);
      mode_e1 = 1'b1;
      std_sel = 1'b0;
      idle(2);
      send_zeros(200);
      check("R10 count restarted on mode change", los_rt, 1'b0);
      send_zeros(54);
      check("R4 no declare at 254", los_rt, 1'b0);
      send_bit(1'b0);
      check("R4 declare at 255", los_rt, 1'b1);
   endtask

   task automatic t_e1_dense;
      send_spaced(255, 1, 31);
      check("R5 31 pulses no clear", los_rt, 1'b1);
      send_spaced(255, 1, 32);
      check("R5 32 pulses clear", los_rt, 1'b0);
   endtask

   task automatic t_e1_sparse;
      std_sel = 1'b1;
      idle(2);
      send_zeros(2047);
      check("R6 no declare at 2047", los_rt, 1'b0);
      send_bit(1'b0);
      check("R6 declare at 2048", los_rt, 1'b1);
      send_zeros(100);
      pulse = 1'b1;
      idle(20);
      pulse = 1'b0;
      send_zeros(155);
      check("R11 unstrobed pulse ignored", los_rt, 1'b1);
      send_zeros(255);
      check("R7 empty window no clear", los_rt, 1'b1);
      for (int i = 0; i < 255; i++) send_bit(i == 200);
      check("R7 single pulse clears", los_rt, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_t1_first_clear;
      t_latch_irq;
      t_t1_declare;
      t_t1_runs;
      t_mode_change;
      t_e1_dense;
      t_e1_sparse;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule